// File: doc/BRIEF.md
# Falling-Edge External Interrupt Latch

This block turns an external pin into an interrupt source. The pin is asynchronous to the core clock, so it is first brought into the clock domain through a chain of synchronizing flops. A high-to-low transition on the synchronized pin sets a sticky pending flag, but only while software has armed the source through the enable bit of a small control word. The pending flag stays set until software writes a one to the clear bit of the same control word, or until reset. A steady low level never sets the flag again.

The pending flag is not sent to the CPU directly. The interrupt request output is high only while the flag is set and the CPU's global interrupt mask input is low. When the CPU acknowledges the request, the block sends a one-cycle pulse that tells the CPU to set its global mask, so the next request is held off until the current service routine ends. The acknowledge does not clear the pending flag. A fixed service-vector address goes out with the request.

Top module: `ext_edge_irq`

## Requirements
- R1: After reset the pending flag and the enable bit are clear, `irq_req` and `imask_set` are 0, and `ctl_rdata` reads 0.
- R2: With enable set (bit 0 of `ctl_wdata`), a high-to-low transition of `pin_async` sets the pending flag. `irq_req` rises by the third rising clock edge after the pin falls, provided `cpu_imask` is 0.
- R3: A rising transition or a steady low level on the pin never sets the pending flag.
- R4: While enable is 0, falling edges are ignored. Setting enable later does not bring an earlier edge back.
- R5: `irq_req` equals the pending flag ANDed with NOT `cpu_imask`, with no register between them.
- R6: A control write with bit 1 of `ctl_wdata` set clears the pending flag at that clock edge. A write with bit 1 at 0 leaves the flag unchanged. Every write also loads enable from bit 0.
- R7: `ctl_rdata` bit 0 returns the enable bit. Bit 1, the clear bit, always reads 0.
- R8: If a clear write and a detected falling edge (with enable set) land on the same clock edge, the flag ends up set.
- R9: `irq_vector` always carries 16'h1FF8.
- R10: A rising edge of `irq_ack` while `irq_req` is high gives exactly one cycle of `imask_set`, on the following clock cycle. The pending flag is not cleared by this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_async | input | 1 | External interrupt pin, asynchronous |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 2 | Bit 0 enable, bit 1 clear (write one to clear) |
| ctl_rdata | output | 2 | Bit 0 enable readback, bit 1 always 0 |
| cpu_imask | input | 1 | CPU global interrupt mask |
| irq_ack | input | 1 | Interrupt acknowledge strobe from the CPU |
| irq_req | output | 1 | Interrupt request to the CPU |
| imask_set | output | 1 | One-cycle request to set the CPU global mask |
| irq_vector | output | 16 | Service-vector address |

## Verification
The assertions assume that `pin_async` stays stable long enough for the synchronizer to register every transition, with at least one clock of high and one of low per edge. They also assume that `irq_ack` is a strobe coming from the core clock domain. The bench changes the pin and all control inputs only on falling clock edges. It holds each pin level for five cycles, so each transition gives exactly one detected edge. The sweep covers every combination of enable, mask and pin transition type, and every mix of clear write and edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned CTL_W    = 2;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned CLR_BIT  = 1;
  localparam int unsigned VEC_W    = 16;
  localparam logic [VEC_W-1:0] VEC_ADDR = 16'h1FF8;

  // high on the previous sample, low on the current one
  function automatic logic is_fall(input logic prev_s, input logic cur_s);
    return prev_s & ~cur_s;
  endfunction

  // a new edge takes priority over a clear
  function automatic logic next_pending(input logic cur, input logic set_e, input logic clr_e);
    if (set_e)      return 1'b1;
    else if (clr_e) return 1'b0;
    else            return cur;
  endfunction
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch
  import ext_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic arm,
  input  logic clr_evt,
  output logic fall_evt,
  output logic pending
);
  logic prev_s;
  logic set_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_s <= 1'b1;
    else        prev_s <= pin_s;
  end

  assign fall_evt = is_fall(prev_s, pin_s);
  assign set_evt  = fall_evt & arm;

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= next_pending(pending, set_evt, clr_evt);
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt && arm |=> pending);
  p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);
  p_noarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !arm && !pending |=> !pending);
  p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt && !(fall_evt && arm) |=> !pending);
  p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt && fall_evt && arm |=> pending);
endmodule

// File: rtl/eirq_gate.sv
module eirq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic cpu_imask,
  input  logic irq_ack,
  output logic irq_req,
  output logic imask_set
);
  logic ack_prev;
  logic ack_rise;

  assign irq_req  = pending & ~cpu_imask;
  assign ack_rise = irq_ack & ~ack_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_prev  <= 1'b0;
      imask_set <= 1'b0;
    end else begin
      ack_prev  <= irq_ack;
      imask_set <= ack_rise & irq_req;
    end
  end

  p_req_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pending && !cpu_imask);
  p_ack_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ack) && irq_req |=> imask_set);
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    imask_set |=> !imask_set);
endmodule

// File: rtl/ext_edge_irq.sv
module ext_edge_irq
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_async,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              cpu_imask,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic              imask_set,
  output logic [VEC_W-1:0]  irq_vector
);
  logic en_q;
  logic pin_s;
  logic clr_evt;
  logic fall_evt;
  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (ctl_wr) en_q <= ctl_wdata[EN_BIT];
  end

  assign clr_evt = ctl_wr & ctl_wdata[CLR_BIT];

  always_comb begin
    ctl_rdata         = '0;
    ctl_rdata[EN_BIT] = en_q;
  end

  assign irq_vector = VEC_ADDR;

  eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_async), .q_sync(pin_s)
  );

  eirq_latch u_latch (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .arm(en_q),
    .clr_evt(clr_evt), .fall_evt(fall_evt), .pending(pending)
  );

  eirq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .pending(pending), .cpu_imask(cpu_imask),
    .irq_ack(irq_ack), .irq_req(irq_req), .imask_set(imask_set)
  );

  p_rd_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[CLR_BIT] == 1'b0);
  p_wr_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_rdata[EN_BIT] == $past(ctl_wdata[EN_BIT]));
endmodule

// File: tb/ext_edge_irq_tb.sv
module ext_edge_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_async = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [1:0] ctl_wdata = 2'b00;
  logic [1:0] ctl_rdata;
  logic       cpu_imask = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq_req;
  logic       imask_set;
  logic [15:0] irq_vector;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ext_edge_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .cpu_imask(cpu_imask),
    .irq_ack(irq_ack), .irq_req(irq_req), .imask_set(imask_set),
    .irq_vector(irq_vector)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one write cycle, driven on falling edges
  task automatic wr(input logic [1:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = 2'b00;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 req", {15'd0, irq_req}, 16'd0);
    chk("R1 mset", {15'd0, imask_set}, 16'd0);
    chk("R1 rdata", {14'd0, ctl_rdata}, 16'd0);
    chk("R9 vector", irq_vector, 16'h1FF8);

    // sweep: enable x mask x transition type (0 fall, 1 rise)
    for (int en = 0; en < 2; en++) begin
      for (int mk = 0; mk < 2; mk++) begin
        for (int pat = 0; pat < 2; pat++) begin
          logic exp_pend;
          @(negedge clk); pin_async = (pat == 0);
          idle(5);
          wr({1'b1, en[0]});
          cpu_imask = mk[0];
          @(negedge clk); pin_async = (pat != 0);
          idle(5);
          exp_pend = (pat == 0) && (en == 1);
          chk(pat == 0 ? "R2 R5 fall masked-view" : "R3 rise masked-view",
              {15'd0, irq_req}, {15'd0, exp_pend & ~mk[0]});
          cpu_imask = 1'b0; #1;
          chk(en == 0 ? "R4 disabled edge" : (pat == 0 ? "R2 fall" : "R3 rise"),
              {15'd0, irq_req}, {15'd0, exp_pend});
          chk("R7 rdata", {14'd0, ctl_rdata}, {15'd0, en[0]});
          idle(5);
          chk("R3 steady level", {15'd0, irq_req}, {15'd0, exp_pend});
          wr(2'b10);
        end
      end
    end

    // R4: edge while disabled is not revived by enabling
    @(negedge clk); pin_async = 1'b1; idle(5);
    wr(2'b00);
    @(negedge clk); pin_async = 1'b0; idle(5);
    wr(2'b01); idle(3);
    chk("R4 late enable", {15'd0, irq_req}, 16'd0);

    // R2 timing: latch on third rising edge after pin falls
    @(negedge clk); pin_async = 1'b1; idle(5);
    @(negedge clk); pin_async = 1'b0;
    idle(2);
    chk("R2 not yet", {15'd0, irq_req}, 16'd0);
    idle(1);
    chk("R2 third edge", {15'd0, irq_req}, 16'd1);

    // R5: combinational masking
    @(negedge clk); cpu_imask = 1'b1; #1;
    chk("R5 mask on", {15'd0, irq_req}, 16'd0);
    cpu_imask = 1'b0; #1;
    chk("R5 mask off", {15'd0, irq_req}, 16'd1);

    // R6: write zero to clear bit keeps flag; one clears it
    wr(2'b01);
    chk("R6 zero no effect", {15'd0, irq_req}, 16'd1);
    wr(2'b11);
    chk("R6 clear", {15'd0, irq_req}, 16'd0);
    chk("R7 clear reads 0", {14'd0, ctl_rdata}, 16'd1);

    // R8: collision, edge wins (flag already set beforehand)
    @(negedge clk); pin_async = 1'b1; idle(5);
    @(negedge clk); pin_async = 1'b0; idle(5);
    @(negedge clk); pin_async = 1'b1; idle(5);
    chk("R8 pre set", {15'd0, irq_req}, 16'd1);
    @(negedge clk); pin_async = 1'b0;
    @(negedge clk);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 2'b11;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = 2'b00;
    chk("R8 edge wins", {15'd0, irq_req}, 16'd1);

    // R10: ack pulses imask_set once, flag remains
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk);
    chk("R10 pulse", {15'd0, imask_set}, 16'd1);
    @(negedge clk); irq_ack = 1'b0;
    chk("R10 one cycle", {15'd0, imask_set}, 16'd0);
    chk("R10 flag kept", {15'd0, irq_req}, 16'd1);
    @(negedge clk); cpu_imask = 1'b1; irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R10 no req no pulse", {15'd0, imask_set}, 16'd0);
    cpu_imask = 1'b0;
    chk("R9 vector hold", irq_vector, 16'h1FF8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule